// File: doc/BRIEF.md
# Host Bus to CAN Controller Interrupt and Decode Glue

This block sits between a simple synchronous host I/O port and a single CAN controller core. The host reaches the block through three windows, each with its own select: a bridge window holding one 32-bit interrupt control/status word, a controller window whose low byte offsets are passed straight through to the core, and a small read-only version window. Any access that misses a defined register reads as zero and is otherwise dropped.

The core's level interrupt reaches the single host interrupt line only while the enable bit of the control/status word is set. Reading that word shows the live interrupt level in its status bit, whatever software last wrote there. When software flips the enable bit while a request is pending, the host line follows on the next clock edge.

Top module: `hostcan_glue`

## Requirements
- R1: A synchronous active-high reset clears the control/status word to zero and drives host_irq and host_rvalid low.
- R2: A bridge write at offset 0x38 stores all 32 data bits. A bridge read at 0x38 returns the stored word with bit 23 replaced by the core interrupt level present at the read strobe.
- R3: One clock edge after any cycle, host_irq equals the core interrupt level of that cycle ANDed with bit 13 of the control/status word as updated in that cycle.
- R4: With the interrupt level high, a write that changes bit 13 drives host_irq to the new bit 13 value one edge after the write strobe.
- R5: Bridge reads at any offset other than 0x38 return zero, and bridge writes there leave the control/status word unchanged.
- R6: Controller window accesses at offsets below 0x20 assert core_wr or core_rd in the strobe cycle, with core_addr equal to the offset and core_wdata equal to host_wdata[7:0]. For a read, the core's byte comes back on host_rdata[7:0] with host_rvalid two edges after the strobe.
- R7: Controller window accesses at offsets 0x20 and above never strobe the core. Such reads return zero one edge after the strobe.
- R8: A version window read at offset 7 returns 0xD0 (version 13 in bits 7:4, zero in bits 3:0). Reads at other version offsets return zero.
- R9: Writes to the version window change nothing: the version byte reads back unchanged and the control/status word keeps its value.
- R10: Bridge and version reads return data with host_rvalid high one edge after the read strobe, as a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel_bridge | input | 1 | Selects the bridge control window |
| host_sel_core | input | 1 | Selects the controller window |
| host_sel_ver | input | 1 | Selects the version window |
| host_addr | input | 7 | Byte offset within the selected window |
| host_wdata | input | 32 | Write data (controller and version windows use bits 7:0) |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid pulse |
| host_irq | output | 1 | Gated, registered host interrupt line |
| core_addr | output | 5 | Register offset toward the controller core |
| core_wdata | output | 8 | Write byte toward the controller core |
| core_wr | output | 1 | Write strobe toward the controller core |
| core_rd | output | 1 | Read strobe toward the controller core |
| core_rdata | input | 8 | Controller read byte, valid one cycle after core_rd |
| core_irq_lvl | input | 1 | Raw controller interrupt level, synchronous to clk |

## Verification
The bench sets bit 23 in written data while the interrupt level is low, and clears it while the level is high. A design that stored the status bit instead of overlaying the live level would then read back the written value. It flips the enable bit with a request pending and checks the line on the very next edge, which catches a design that waits for a later level change. It probes controller offsets at 0x1F, 0x20 and 0x7F and counts core strobes, so an off-by-one in the forwarding limit or a leaked strobe shows up as a wrong count or a nonzero read. Random mixes of all windows and level changes also catch a wrong read latency on the forwarded path.

// File: rtl/hcg_pkg.sv
package hcg_pkg;

    localparam int HOST_AW = 7;
    localparam int HOST_DW = 32;
    localparam int CORE_AW = 5;
    localparam int CORE_DW = 8;

    localparam logic [HOST_AW-1:0] CSR_OFFSET   = 7'h38;
    localparam int                 IRQ_EN_BIT   = 13;
    localparam int                 IRQ_LIVE_BIT = 23;
    localparam logic [HOST_AW-1:0] CORE_LIMIT   = 7'h20;
    localparam logic [HOST_AW-1:0] VER_OFFSET   = 7'h07;

    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_BRIDGE = 2'd1,
        WIN_CORE   = 2'd2,
        WIN_VER    = 2'd3
    } win_e;

    typedef struct packed {
        win_e               win;
        logic               rd;
        logic               wr;
        logic [HOST_AW-1:0] off;
        logic [HOST_DW-1:0] wdata;
    } host_req_t;

    typedef struct packed {
        logic               valid;
        logic [HOST_DW-1:0] data;
    } rd_ret_t;

    // Bridge select wins over the controller, which wins over version.
    function automatic win_e pick_window(input logic b, input logic c, input logic v);
        if (b)      return WIN_BRIDGE;
        else if (c) return WIN_CORE;
        else if (v) return WIN_VER;
        else        return WIN_NONE;
    endfunction

    function automatic logic [HOST_DW-1:0] overlay_live(input logic [HOST_DW-1:0] stored,
                                                        input logic lvl);
        logic [HOST_DW-1:0] v;
        v = stored;
        v[IRQ_LIVE_BIT] = lvl;
        return v;
    endfunction

    function automatic logic [CORE_DW-1:0] version_byte(input logic [HOST_AW-1:0] off,
                                                        input logic [3:0] num);
        return (off == VER_OFFSET) ? {num, 4'h0} : '0;
    endfunction

endpackage

// File: rtl/hcg_bridge_regs.sv
module hcg_bridge_regs
    import hcg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  win_e               win,
    input  logic               wr,
    input  logic [HOST_AW-1:0] off,
    input  logic [HOST_DW-1:0] wdata,
    input  logic               irq_lvl,
    output logic [HOST_DW-1:0] csr_q,
    output logic [HOST_DW-1:0] rd_word,
    output logic               irq_q
);

    logic               hit_csr;
    logic [HOST_DW-1:0] csr_d;

    always_comb begin
        hit_csr = (win == WIN_BRIDGE) && (off == CSR_OFFSET);
        csr_d   = (hit_csr && wr) ? wdata : csr_q;
        rd_word = hit_csr ? overlay_live(csr_q, irq_lvl) : '0;
    end

    // The gate uses the enable as it stands after this edge, so a write
    // that flips the enable moves the line on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q <= '0;
            irq_q <= 1'b0;
        end else begin
            csr_q <= csr_d;
            irq_q <= irq_lvl & csr_d[IRQ_EN_BIT];
        end
    end

endmodule

// File: rtl/hcg_core_port.sv
module hcg_core_port
    import hcg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  win_e               win,
    input  logic               rd,
    input  logic               wr,
    input  logic [HOST_AW-1:0] off,
    input  logic [CORE_DW-1:0] wbyte,
    output logic [CORE_AW-1:0] core_addr,
    output logic [CORE_DW-1:0] core_wdata,
    output logic               core_wr,
    output logic               core_rd,
    output logic               fwd_hit,
    output logic               pend_q
);

    always_comb begin
        fwd_hit    = (win == WIN_CORE) && (off < CORE_LIMIT);
        core_addr  = off[CORE_AW-1:0];
        core_wdata = wbyte;
        core_wr    = fwd_hit && wr;
        core_rd    = fwd_hit && rd;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= core_rd;
    end

endmodule

// File: rtl/hcg_ver_win.sv
module hcg_ver_win
    import hcg_pkg::*;
#(
    parameter logic [3:0] VER_NUMBER = 4'd13
) (
    input  win_e               win,
    input  logic [HOST_AW-1:0] off,
    output logic [CORE_DW-1:0] rd_byte
);

    always_comb begin
        rd_byte = (win == WIN_VER) ? version_byte(off, VER_NUMBER) : '0;
    end

endmodule

// File: rtl/hcg_read_ret.sv
module hcg_read_ret
    import hcg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  win_e               win,
    input  logic               rd,
    input  logic               fwd_hit,
    input  logic               pend,
    input  logic [HOST_DW-1:0] bridge_word,
    input  logic [CORE_DW-1:0] ver_byte,
    input  logic [CORE_DW-1:0] core_byte,
    output rd_ret_t            ret_q
);

    rd_ret_t ret_d;

    always_comb begin
        ret_d.valid = 1'b0;
        ret_d.data  = ret_q.data;
        if (pend) begin
            ret_d.valid = 1'b1;
            ret_d.data  = {{(HOST_DW-CORE_DW){1'b0}}, core_byte};
        end else if (rd) begin
            unique case (win)
                WIN_BRIDGE: begin
                    ret_d.valid = 1'b1;
                    ret_d.data  = bridge_word;
                end
                WIN_VER: begin
                    ret_d.valid = 1'b1;
                    ret_d.data  = {{(HOST_DW-CORE_DW){1'b0}}, ver_byte};
                end
                WIN_CORE: begin
                    if (!fwd_hit) begin
                        ret_d.valid = 1'b1;
                        ret_d.data  = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ret_q <= '0;
        else     ret_q <= ret_d;
    end

endmodule

// File: rtl/hostcan_glue.sv
module hostcan_glue
    import hcg_pkg::*;
#(
    parameter logic [3:0] VER_NUMBER = 4'd13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_sel_bridge,
    input  logic               host_sel_core,
    input  logic               host_sel_ver,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    input  logic               host_wr,
    input  logic               host_rd,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               host_rvalid,
    output logic               host_irq,
    output logic [CORE_AW-1:0] core_addr,
    output logic [CORE_DW-1:0] core_wdata,
    output logic               core_wr,
    output logic               core_rd,
    input  logic [CORE_DW-1:0] core_rdata,
    input  logic               core_irq_lvl
);

    host_req_t          req;
    logic [HOST_DW-1:0] csr_q;
    logic [HOST_DW-1:0] bridge_word;
    logic [CORE_DW-1:0] ver_byte;
    logic               fwd_hit;
    logic               pend_q;
    rd_ret_t            ret_q;

    always_comb begin
        req.win   = pick_window(host_sel_bridge, host_sel_core, host_sel_ver);
        req.rd    = host_rd;
        req.wr    = host_wr;
        req.off   = host_addr;
        req.wdata = host_wdata;
    end

    hcg_bridge_regs u_bridge (
        .clk     (clk),
        .rst     (rst),
        .win     (req.win),
        .wr      (req.wr),
        .off     (req.off),
        .wdata   (req.wdata),
        .irq_lvl (core_irq_lvl),
        .csr_q   (csr_q),
        .rd_word (bridge_word),
        .irq_q   (host_irq)
    );

    hcg_core_port u_core (
        .clk        (clk),
        .rst        (rst),
        .win        (req.win),
        .rd         (req.rd),
        .wr         (req.wr),
        .off        (req.off),
        .wbyte      (req.wdata[CORE_DW-1:0]),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .core_wr    (core_wr),
        .core_rd    (core_rd),
        .fwd_hit    (fwd_hit),
        .pend_q     (pend_q)
    );

    hcg_ver_win #(.VER_NUMBER(VER_NUMBER)) u_ver (
        .win     (req.win),
        .off     (req.off),
        .rd_byte (ver_byte)
    );

    hcg_read_ret u_ret (
        .clk         (clk),
        .rst         (rst),
        .win         (req.win),
        .rd          (req.rd),
        .fwd_hit     (fwd_hit),
        .pend        (pend_q),
        .bridge_word (bridge_word),
        .ver_byte    (ver_byte),
        .core_byte   (core_rdata),
        .ret_q       (ret_q)
    );

    assign host_rdata  = ret_q.data;
    assign host_rvalid = ret_q.valid;

endmodule

// File: rtl/hostcan_glue_chk.sv
module hostcan_glue_chk
    import hcg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sel_b,
    input logic               sel_c,
    input logic               sel_v,
    input logic [HOST_AW-1:0] addr,
    input logic [HOST_DW-1:0] wdata,
    input logic               wr,
    input logic               rd,
    input logic [HOST_DW-1:0] rdata,
    input logic               rvalid,
    input logic               irq,
    input logic               c_wr,
    input logic               c_rd,
    input logic               lvl,
    input logic [HOST_DW-1:0] csr
);

    logic only_b, only_c, only_v;
    assign only_b = sel_b && !sel_c && !sel_v;
    assign only_c = sel_c && !sel_b && !sel_v;
    assign only_v = sel_v && !sel_b && !sel_c;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!irq && !rvalid && csr == '0));

    p_live_status_r2: assert property (@(posedge clk) disable iff (rst)
        (rd && only_b && addr == CSR_OFFSET) |=> (rdata[IRQ_LIVE_BIT] == $past(lvl)));

    p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == ($past(lvl) && csr[IRQ_EN_BIT])));

    p_en_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && only_b && addr == CSR_OFFSET && lvl && (wdata[IRQ_EN_BIT] != csr[IRQ_EN_BIT]))
        |=> (irq == $past(wdata[IRQ_EN_BIT])));

    p_other_bridge_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && only_b && addr != CSR_OFFSET) |=> $stable(csr));

    p_no_fwd_high_r7: assert property (@(posedge clk) disable iff (rst)
        ((wr || rd) && only_c && addr >= CORE_LIMIT) |-> (!c_wr && !c_rd));

    p_ver_byte_r8: assert property (@(posedge clk) disable iff (rst)
        (rd && only_v && addr == VER_OFFSET) |=> (rdata == 32'h0000_00D0));

    p_ver_write_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && only_v) |-> (!c_wr && !c_rd));

    p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
        (rd && (only_b || only_v)) |=> rvalid);

endmodule

bind hostcan_glue hostcan_glue_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .sel_b  (host_sel_bridge),
    .sel_c  (host_sel_core),
    .sel_v  (host_sel_ver),
    .addr   (host_addr),
    .wdata  (host_wdata),
    .wr     (host_wr),
    .rd     (host_rd),
    .rdata  (host_rdata),
    .rvalid (host_rvalid),
    .irq    (host_irq),
    .c_wr   (core_wr),
    .c_rd   (core_rd),
    .lvl    (core_irq_lvl),
    .csr    (csr_q)
);

// File: tb/hostcan_glue_tb_top.sv
module hostcan_glue_tb_top;

    localparam int WB = 0, WC = 1, WV = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_b, sel_c, sel_v;
    logic [6:0]  addr;
    logic [31:0] wdata;
    logic        wr, rd;
    logic [31:0] rdata;
    logic        rvalid, irq;
    logic [4:0]  c_addr;
    logic [7:0]  c_wdata;
    logic        c_wr, c_rd;
    logic [7:0]  c_rdata;
    logic        lvl;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit done = 0;

    logic [31:0] exp_csr;
    logic [7:0]  exp_mem [32];
    logic [7:0]  core_mem [32];

    always #5 clk = ~clk;

    hostcan_glue dut_i (
        .clk(clk), .rst(rst),
        .host_sel_bridge(sel_b), .host_sel_core(sel_c), .host_sel_ver(sel_v),
        .host_addr(addr), .host_wdata(wdata), .host_wr(wr), .host_rd(rd),
        .host_rdata(rdata), .host_rvalid(rvalid), .host_irq(irq),
        .core_addr(c_addr), .core_wdata(c_wdata), .core_wr(c_wr), .core_rd(c_rd),
        .core_rdata(c_rdata), .core_irq_lvl(lvl)
    );

    // Controller model: registered read, one cycle latency.
    always @(posedge clk) begin
        if (c_rd) c_rdata <= core_mem[c_addr];
        if (c_wr) core_mem[c_addr] <= c_wdata;
        if (c_wr || c_rd) strobes <= strobes + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] exp_status(input logic [31:0] c, input logic l);
        logic [31:0] v;
        v = c;
        v[23] = l;
        return v;
    endfunction

    function automatic logic [31:0] exp_ver(input logic [6:0] a);
        return (a == 7'd7) ? 32'hD0 : 32'h0;
    endfunction

    task automatic select(input int w);
        sel_b = (w == WB);
        sel_c = (w == WC);
        sel_v = (w == WV);
    endtask

    task automatic idle;
        sel_b = 0; sel_c = 0; sel_v = 0; wr = 0; rd = 0;
    endtask

    task automatic host_write(input int w, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        select(w); addr = a; wdata = d; wr = 1;
        @(negedge clk);
        idle();
        if (w == WB && a == 7'h38) exp_csr = d;
        if (w == WC && a < 7'h20) exp_mem[a[4:0]] = d[7:0];
    endtask

    task automatic host_read(input int w, input logic [6:0] a,
                             output logic [31:0] d, output int lat);
        @(negedge clk);
        select(w); addr = a; rd = 1;
        @(negedge clk);
        idle();
        lat = 1;
        while (!rvalid && lat < 4) begin
            @(negedge clk);
            lat++;
        end
        d = rdata;
    endtask

    task automatic check_irq(input string req);
        check(irq == (lvl & exp_csr[13]), req, {31'b0, irq}, {31'b0, lvl & exp_csr[13]});
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        int lat;
        int s0;
        void'($urandom(32'h1A2B3C4D));
        idle(); addr = 0; wdata = 0; lvl = 0; rst = 1; exp_csr = 0;
        for (int i = 0; i < 32; i++) begin
            exp_mem[i] = 8'h00;
            core_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(irq == 0, "R1 irq", {31'b0, irq}, 0);
        check(rvalid == 0, "R1 rvalid", {31'b0, rvalid}, 0);
        rst = 0;
        host_read(WB, 7'h38, d, lat);
        check(d == 32'h0, "R1 csr", d, 0);

        // R2 full store and live overlay in both directions
        host_write(WB, 7'h38, 32'hFFFF_DFFF);
        host_read(WB, 7'h38, d, lat);
        check(d == exp_status(exp_csr, 0), "R2 overlay low", d, exp_status(exp_csr, 0));
        check(lat == 1, "R10 bridge latency", lat, 1);
        @(negedge clk); lvl = 1;
        host_write(WB, 7'h38, 32'h1234_5678 & ~32'h0080_2000);
        host_read(WB, 7'h38, d, lat);
        check(d == exp_status(exp_csr, 1), "R2 overlay high", d, exp_status(exp_csr, 1));
        check_irq("R3 disabled");

        // R4 enable toggles with request pending
        host_write(WB, 7'h38, 32'h0000_2000);
        check(irq == 1, "R4 enable on", {31'b0, irq}, 1);
        host_write(WB, 7'h38, 32'h0080_0000);
        check(irq == 0, "R4 enable off", {31'b0, irq}, 0);
        host_write(WB, 7'h38, 32'h0000_2000);
        @(negedge clk); lvl = 0;
        @(negedge clk);
        check_irq("R3 level drop");

        // R5 other bridge offsets
        host_write(WB, 7'h3C, 32'hFFFF_FFFF);
        host_read(WB, 7'h3C, d, lat);
        check(d == 0, "R5 other read", d, 0);
        host_read(WB, 7'h38, d, lat);
        check(d == exp_status(exp_csr, lvl), "R5 csr kept", d, exp_status(exp_csr, lvl));

        // R6 / R7 controller window boundaries
        host_write(WC, 7'h1F, 32'hFFFF_FF5A);
        host_read(WC, 7'h1F, d, lat);
        check(d == 32'h5A, "R6 fwd data", d, 32'h5A);
        check(lat == 2, "R6 fwd latency", lat, 2);
        s0 = strobes;
        host_write(WC, 7'h20, 32'hA5);
        host_write(WC, 7'h7F, 32'hC3);
        host_read(WC, 7'h20, d, lat);
        check(d == 0, "R7 high read", d, 0);
        check(lat == 1, "R7 high latency", lat, 1);
        check(strobes == s0, "R7 no strobe", strobes, s0);
        host_read(WC, 7'h00, d, lat);
        check(d == {24'b0, exp_mem[0]}, "R7 low alias untouched", d, {24'b0, exp_mem[0]});

        // R8 / R9 version window
        host_read(WV, 7'd7, d, lat);
        check(d == 32'hD0, "R8 version", d, 32'hD0);
        check(lat == 1, "R10 version latency", lat, 1);
        host_read(WV, 7'd3, d, lat);
        check(d == 0, "R8 other offset", d, 0);
        host_write(WV, 7'd7, 32'h0000_0000);
        host_read(WV, 7'd7, d, lat);
        check(d == 32'hD0, "R9 write ignored", d, 32'hD0);
        host_read(WB, 7'h38, d, lat);
        check(d == exp_status(exp_csr, lvl), "R9 csr kept", d, exp_status(exp_csr, lvl));

        // Random mix
        for (int it = 0; it < 500; it++) begin
            int op;
            logic [6:0] a;
            logic [31:0] v;
            op = $urandom_range(0, 6);
            a = 7'($urandom_range(0, 127));
            v = $urandom();
            case (op)
                0: host_write(WB, ($urandom_range(0, 1) != 0) ? 7'h38 : a, v);
                1: begin
                    host_read(WB, 7'h38, d, lat);
                    check(d == exp_status(exp_csr, lvl), "R2 random", d, exp_status(exp_csr, lvl));
                end
                2: begin
                    @(negedge clk); lvl = ~lvl;
                    @(negedge clk);
                end
                3: host_write(WC, a, v);
                4: begin
                    host_read(WC, a, d, lat);
                    if (a < 7'h20)
                        check(d == {24'b0, exp_mem[a[4:0]]} && lat == 2, "R6 random", d,
                              {24'b0, exp_mem[a[4:0]]});
                    else
                        check(d == 0 && lat == 1, "R7 random", d, 0);
                end
                5: begin
                    host_read(WV, {4'b0, a[2:0]}, d, lat);
                    check(d == exp_ver({4'b0, a[2:0]}), "R8 random", d, exp_ver({4'b0, a[2:0]}));
                end
                default: begin
                    host_read(WB, (a == 7'h38) ? 7'h00 : a, d, lat);
                    check(d == 0, "R5 random", d, 0);
                end
            endcase
            check_irq("R3 random");
        end

        done = 1;
        finish_run();
    end

endmodule